// File: doc/BRIEF.md
# Watchdog-Capable Countdown Timer

This block is a single memory-mapped countdown timer that can be designated as the system watchdog. Software reaches it through a plain 32-bit register port. The port has a write strobe, a read strobe and a byte address. Behind the port sit four registers: a control word, two words that together hold a 64-bit start count, and a watchdog-select word. Once enabled in one-shot mode, the timer loads the start count and steps it down by one every P input clocks, where P is the prescaler field. When the count reaches zero the timer stops. If the select word names this timer, a reset request pulse goes out.

To re-arm the timer, software clears the enable bit, writes both count words, and sets the enable bit again. Only a rising enable copies the stored count into the running counter. Count writes made while the timer is enabled are therefore kept for the next arming and do not touch the run in progress. Arming with a count of zero forces an immediate expiry, which software uses to trigger the watchdog reset at once.

Top module: `wdog_timer`

## Requirements
- R1: After reset, every register reads zero, the timer is idle and `rst_req` is low.
- R2: The control word is at address 0x10. Its fields are: enable at bit 0, a read-only running flag at bit 1, mode at bits 3:2, and prescaler at bits 15:8. All other bits read zero. The start count low word is at 0x14 and the high word at 0x18; both read back as written. The select word is at 0x00 and reads back as written. Unmapped addresses read zero.
- R3: A control write that raises enable with mode 0 loads the start count N and sets the running flag. The flag falls N*P clocks after that write's clock edge.
- R4: A prescaler value of 0 or 1 counts as 2.
- R5: Arming with a start count of zero leaves the running flag low. It raises the expiry on the very edge of the arming write, so `rst_req` is high in the following cycle.
- R6: At expiry, `rst_req` is high for exactly one clock, and only if bit 1 of the select word is set. Other select bits have no effect.
- R7: Writes to either count word while the timer is enabled change the stored value but leave the current run's expiry time unchanged.
- R8: Writing enable low stops the count at once and clears the running flag. No expiry follows, even when the write lands on the final count step.
- R9: A control write that keeps enable at 1 does not restart the count.
- R10: Raising enable with a mode value other than 0 does not start the timer.
- R11: The high count word takes part in the count: a start count of 2^32 keeps the timer running well past any expiry time the low word alone could give.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Register byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data; valid combinationally while rd_en is high |
| rst_req | output | 1 | One-cycle watchdog reset request |

## Verification
The hardest case to reach is a disable write that arrives on the same edge as the final count step. In that case the stop must win and no reset request may leak out. The stimulus arms a count of 1 with prescaler 2 and issues the disabling write exactly two edges after the arming edge. The bench then watches `rst_req` for several cycles. Count rewrites during a run and repeated enable writes are timed in the same way, one edge after arming, so that the expected expiry edge stays fixed and can be checked to the cycle.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 8;
    localparam int CNT_W    = 2 * DATA_W;
    localparam int PS_W     = 8;
    localparam int MODE_W   = 2;
    localparam int PS_MIN   = 2;

    localparam logic [ADDR_W-1:0] OFF_SEL  = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_CTRL = 8'h10;
    localparam logic [ADDR_W-1:0] OFF_LO   = 8'h14;
    localparam logic [ADDR_W-1:0] OFF_HI   = 8'h18;

    localparam int EN_BIT   = 0;
    localparam int ACT_BIT  = 1;
    localparam int MODE_LSB = 2;
    localparam int PS_LSB   = 8;

    typedef enum logic [MODE_W-1:0] {
        MODE_ONESHOT = 2'd0,
        MODE_RSVD1   = 2'd1,
        MODE_RSVD2   = 2'd2,
        MODE_RSVD3   = 2'd3
    } mode_e;

    typedef struct packed {
        logic [PS_W-1:0] ps;
        mode_e           mode;
        logic            en;
    } ctrl_t;

    typedef struct packed {
        logic start;
        logic stop;
    } cmd_t;

    function automatic logic [PS_W-1:0] eff_ps(input logic [PS_W-1:0] raw);
        return (raw < PS_W'(PS_MIN)) ? PS_W'(PS_MIN) : raw;
    endfunction

    function automatic ctrl_t word_to_ctrl(input logic [DATA_W-1:0] w);
        ctrl_t c;
        c.en   = w[EN_BIT];
        c.mode = mode_e'(w[MODE_LSB +: MODE_W]);
        c.ps   = w[PS_LSB +: PS_W];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_to_word(input ctrl_t c, input logic act);
        logic [DATA_W-1:0] w;
        w                    = '0;
        w[EN_BIT]            = c.en;
        w[ACT_BIT]           = act;
        w[MODE_LSB +: MODE_W] = c.mode;
        w[PS_LSB +: PS_W]    = c.ps;
        return w;
    endfunction

endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              active,
    output logic [DATA_W-1:0] rdata,
    output ctrl_t             ctrl,
    output logic [CNT_W-1:0]  load,
    output logic [DATA_W-1:0] sel,
    output cmd_t              cmd
);

    ctrl_t             ctrl_q;
    ctrl_t             ctrl_new;
    logic [DATA_W-1:0] lo_q;
    logic [DATA_W-1:0] hi_q;
    logic [DATA_W-1:0] sel_q;
    logic              wr_ctrl;
    logic              unused_wbits;

    assign wr_ctrl  = wr_en && (addr == OFF_CTRL);
    assign ctrl_new = word_to_ctrl(wdata);
    assign unused_wbits = ^{wdata[DATA_W-1:PS_LSB+PS_W], wdata[PS_LSB-1:MODE_LSB+MODE_W], wdata[ACT_BIT]};

    always_comb begin
        cmd.start = wr_ctrl && ctrl_new.en && !ctrl_q.en && (ctrl_new.mode == MODE_ONESHOT);
        cmd.stop  = wr_ctrl && !ctrl_new.en && ctrl_q.en;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            lo_q   <= '0;
            hi_q   <= '0;
            sel_q  <= '0;
        end else if (wr_en) begin
            case (addr)
                OFF_CTRL: ctrl_q <= ctrl_new;
                OFF_LO:   lo_q   <= wdata;
                OFF_HI:   hi_q   <= wdata;
                OFF_SEL:  sel_q  <= wdata;
                default:  ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (addr)
                OFF_CTRL: rdata = ctrl_to_word(ctrl_q, active);
                OFF_LO:   rdata = lo_q;
                OFF_HI:   rdata = hi_q;
                OFF_SEL:  rdata = sel_q;
                default:  rdata = '0;
            endcase
        end
    end

    assign ctrl = ctrl_q;
    assign load = {hi_q, lo_q};
    assign sel  = sel_q;

    // R9
    start_from_idle_chk: assert property (@(posedge clk) disable iff (rst)
        cmd.start |=> ctrl_q.en && (ctrl_q.mode == MODE_ONESHOT));

    // R2
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && addr == OFF_CTRL) |=> $stable(ctrl_q));

endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler
    import wdt_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            run,
    input  logic            clear,
    input  logic [PS_W-1:0] ps_raw,
    output logic            tick
);

    logic [PS_W-1:0] pcnt_q;
    logic [PS_W-1:0] ps_eff;

    assign ps_eff = eff_ps(ps_raw);
    assign tick   = run && (pcnt_q >= ps_eff - PS_W'(1));

    always_ff @(posedge clk) begin
        if (rst || clear || !run) begin
            pcnt_q <= '0;
        end else if (tick) begin
            pcnt_q <= '0;
        end else begin
            pcnt_q <= pcnt_q + PS_W'(1);
        end
    end

    // R4
    tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
    import wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             stop,
    input  logic             tick,
    input  logic [CNT_W-1:0] load,
    output logic             active,
    output logic             expire
);

    logic [CNT_W-1:0] cnt_q;
    logic             active_q;
    logic             expire_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            active_q <= 1'b0;
            expire_q <= 1'b0;
        end else begin
            expire_q <= 1'b0;
            if (start) begin
                cnt_q <= load;
                if (load == '0) begin
                    active_q <= 1'b0;
                    expire_q <= 1'b1;
                end else begin
                    active_q <= 1'b1;
                end
            end else if (stop) begin
                active_q <= 1'b0;
            end else if (active_q && tick) begin
                cnt_q <= cnt_q - CNT_W'(1);
                if (cnt_q == CNT_W'(1)) begin
                    active_q <= 1'b0;
                    expire_q <= 1'b1;
                end
            end
        end
    end

    assign active = active_q;
    assign expire = expire_q;

    // R3
    load_on_start_chk: assert property (@(posedge clk) disable iff (rst)
        (start && load != '0) |=> active_q && (cnt_q == $past(load)));

    // R5
    zero_load_chk: assert property (@(posedge clk) disable iff (rst)
        (start && load == '0) |=> expire_q && !active_q);

    // R8
    stop_clear_chk: assert property (@(posedge clk) disable iff (rst)
        stop |=> !active_q && !expire_q);

    // R6
    expire_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        expire_q |=> !expire_q);

    // R3
    expire_idle_chk: assert property (@(posedge clk) disable iff (rst)
        expire_q |-> !active_q);

    // R7
    count_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (active_q && !tick && !start && !stop) |=> $stable(cnt_q));

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
    import wdt_pkg::*;
#(
    parameter int TIMER_IDX = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rst_req
);

    ctrl_t             ctrl;
    cmd_t              cmd;
    logic [CNT_W-1:0]  load;
    logic [DATA_W-1:0] sel;
    logic              active;
    logic              expire;
    logic              tick;

    wdt_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .rd_en  (rd_en),
        .addr   (addr),
        .wdata  (wdata),
        .active (active),
        .rdata  (rdata),
        .ctrl   (ctrl),
        .load   (load),
        .sel    (sel),
        .cmd    (cmd)
    );

    wdt_prescaler u_pre (
        .clk    (clk),
        .rst    (rst),
        .run    (active),
        .clear  (cmd.start),
        .ps_raw (ctrl.ps),
        .tick   (tick)
    );

    wdt_counter u_cnt (
        .clk    (clk),
        .rst    (rst),
        .start  (cmd.start),
        .stop   (cmd.stop),
        .tick   (tick),
        .load   (load),
        .active (active),
        .expire (expire)
    );

    assign rst_req = expire && sel[TIMER_IDX];

    // R6
    req_needs_run_chk: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> !active);

endmodule

// File: tb/wdog_timer_tb.sv
module wdog_timer_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic        rd_en;
    logic [7:0]  addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic        rst_req;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    wdog_timer u_dut (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .addr    (addr),
        .wdata   (wdata),
        .rdata   (rdata),
        .rst_req (rst_req)
    );

    localparam int NV = 5;
    localparam int V_LOAD [NV] = '{3, 2, 1, 4, 5};
    localparam int V_PS   [NV] = '{2, 5, 0, 1, 3};
    localparam int V_SEL  [NV] = '{2, 2, 2, 1, 2};

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; addr = '0; wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        rd_en = 1'b1; addr = a;
        #1;
        d = rdata;
        rd_en = 1'b0; addr = '0;
    endtask

    task automatic active_is(input string req, input logic exp);
        logic [31:0] d;
        rd(8'h10, d);
        check(req, {63'd0, d[1]}, {63'd0, exp});
    endtask

    task automatic arm(input int n, input int ps);
        wr(8'h10, 32'h0);
        wr(8'h14, n);
        wr(8'h18, 32'h0);
        wr(8'h10, (ps << 8) | 1);
    endtask

    task automatic expect_expiry(input string req, input int edges_left, input logic sel_on);
        repeat (edges_left - 1) @(negedge clk);
        active_is(req, 1'b1);
        check(req, {63'd0, rst_req}, 64'd0);
        @(negedge clk);
        active_is(req, 1'b0);
        check(req, {63'd0, rst_req}, {63'd0, sel_on});
        @(negedge clk);
        check(req, {63'd0, rst_req}, 64'd0);
    endtask

    task automatic quiet(input string req, input int n);
        int seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (rst_req) seen++;
        end
        check(req, seen, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] d;
        rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(8'h10, d); check("R1", d, 0);
        rd(8'h14, d); check("R1", d, 0);
        rd(8'h18, d); check("R1", d, 0);
        rd(8'h00, d); check("R1", d, 0);
        check("R1", {63'd0, rst_req}, 0);

        // R2 field layout and readback (mode 3 does not start: R10)
        wr(8'h10, 32'hFFFF_FFFF);
        rd(8'h10, d); check("R2", d, 32'h0000_FF0D);
        wr(8'h10, 32'h0);
        wr(8'h14, 32'hA5A5_0001); rd(8'h14, d); check("R2", d, 32'hA5A5_0001);
        wr(8'h18, 32'h1234_5678); rd(8'h18, d); check("R2", d, 32'h1234_5678);
        rd(8'h04, d); check("R2", d, 0);

        // R3 R4 R6 vector table
        for (int v = 0; v < NV; v++) begin
            int pe;
            pe = (V_PS[v] < 2) ? 2 : V_PS[v];
            wr(8'h00, V_SEL[v]);
            arm(V_LOAD[v], V_PS[v]);
            expect_expiry("R3/R4/R6", V_LOAD[v] * pe, V_SEL[v][1]);
        end
        wr(8'h00, 32'h2);

        // R5 zero count forces immediate expiry
        arm(0, 2);
        check("R5", {63'd0, rst_req}, 1);
        active_is("R5", 1'b0);
        @(negedge clk);
        check("R5", {63'd0, rst_req}, 0);

        // R7 count write during run leaves expiry time alone
        arm(4, 2);
        wr(8'h14, 32'd100);
        expect_expiry("R7", 7, 1'b1);
        rd(8'h14, d); check("R7", d, 100);

        // R9 repeated enable write does not restart
        arm(4, 2);
        wr(8'h10, (2 << 8) | 1);
        expect_expiry("R9", 7, 1'b1);

        // R8 disable mid-run
        arm(10, 2);
        repeat (5) @(negedge clk);
        wr(8'h10, 32'h0);
        active_is("R8", 1'b0);
        quiet("R8", 30);

        // R8 disable on the final count step
        arm(1, 2);
        @(negedge clk);
        wr(8'h10, 32'h0);
        check("R8", {63'd0, rst_req}, 0);
        quiet("R8", 5);

        // R10 non-zero mode does not start
        wr(8'h14, 32'd3);
        wr(8'h10, (2 << 8) | (1 << 2) | 1);
        active_is("R10", 1'b0);
        quiet("R10", 20);
        rd(8'h10, d); check("R10", d, (2 << 8) | (1 << 2) | 1);
        wr(8'h10, 32'h0);

        // R11 high word counts
        wr(8'h14, 32'h0);
        wr(8'h18, 32'h1);
        wr(8'h10, (2 << 8) | 1);
        quiet("R11", 50);
        active_is("R11", 1'b1);
        wr(8'h10, 32'h0);

        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule